// File: doc/BRIEF.md
# Key Slot Allocator with Reserved Secure Slot

This block hands out key-slot numbers to clients of a cipher engine and takes them back when the clients are done. The engine has a fixed pool of slots. One of them holds a secure key that is installed at boot, and it is kept out of circulation for good. Every other slot lives in a free list that works as a queue: an allocation takes the oldest free slot, and a release puts the slot at the back. Slot reuse therefore rotates through the pool instead of always favouring low numbers.

A client raises `alloc_req` for one cycle. On the next cycle `alloc_vld` is high, and `alloc_ok` shows whether a slot was granted. When it was, `alloc_slot` carries the slot number. A slot goes back to the pool with a one-cycle `rel_en` strobe and the slot number on `rel_slot`. Two kinds of release are refused. A release that names the secure slot is dropped without a trace. A release of a slot that is already free is dropped, and it raises a sticky `dup_err` flag that only reset clears. `free_cnt` always shows how many slots the pool holds.

Top module: `kslot_alloc`

## Requirements
- R1: After a synchronous active-low reset, `free_cnt` is 7, `dup_err` is 0 and `alloc_vld` is 0.
- R2: Starting from reset, seven allocations with no release in between grant the slots 0, 1, 2, 3, 5, 6 and 7, in that order.
- R3: `alloc_vld` is high in the cycle after a cycle with `alloc_req` high, and low in the cycle after a cycle with `alloc_req` low.
- R4: A request made when the pool is empty, with no accepted release in the same cycle, answers `alloc_ok`=0 and `alloc_slot`=0, and `free_cnt` stays 0.
- R5: An accepted release puts the slot at the tail of the pool, so it is granted only after every slot that was already free.
- R6: A release naming slot 4 changes nothing: `free_cnt` keeps its value, `dup_err` stays 0, and slot 4 is never granted afterwards.
- R7: A release naming a slot that is already free is ignored, so `free_cnt` keeps its value and the slot is granted only once. It also sets `dup_err`, which stays 1 until reset.
- R8: When an allocation and an accepted release meet in the same cycle and the pool is not empty, the head slot is granted, the released slot joins the tail, and `free_cnt` does not change.
- R9: When an allocation and an accepted release meet in the same cycle and the pool is empty, the released slot is granted at once and `free_cnt` stays 0.
- R10: `free_cnt` never exceeds 7, and a granted response never carries slot 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Request one slot (one cycle per request) |
| rel_en | input | 1 | Return the slot on `rel_slot` to the pool |
| rel_slot | input | 3 | Slot being returned |
| alloc_vld | output | 1 | Response to last cycle's request is present |
| alloc_ok | output | 1 | 1 = slot granted, 0 = no slot available |
| alloc_slot | output | 3 | Granted slot number (0 when not granted) |
| free_cnt | output | 4 | Number of slots in the pool |
| dup_err | output | 1 | Sticky flag: a free slot was released again |

## Verification
The bench builds the block with its default values: eight slots with slot 4 reserved. At that size the whole pool can be emptied and refilled within a short run. This reaches the empty-pool refusal, the same-cycle bypass when the pool is empty, and the rotation of released slots behind the slots that were already free. A duplicate release made after the pool has refilled shows at the ports that the duplicate never reaches the queue.

// File: rtl/kslot_pkg.sv
// Package: shared helpers for the key slot allocator.
// Assumes the slot count is a power of two, so every slot-number code is a real slot.
package kslot_pkg;

    // Maps a pool position to the slot number it holds at reset, skipping the reserved slot.
    function automatic int unsigned boot_slot(input int unsigned pos, input int unsigned resv);
        return (pos < resv) ? pos : pos + 1;
    endfunction

endpackage

// File: rtl/kslot_fifo.sv
// Module: kslot_fifo
// A circular queue of slot numbers that holds the free pool. At reset it is filled
// with every non-reserved slot in ascending order. Assumes the caller never pushes
// when full and never pops when empty.
module kslot_fifo #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
    localparam int unsigned DEPTH  = NUM_SLOTS - 1,
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              pop,
    output logic [SLOT_W-1:0] head_slot,
    output logic [CNT_W-1:0]  count
);
    import kslot_pkg::*;

    logic [SLOT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;

    // Moves a pointer forward one place, wrapping at the queue depth.
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_slot = mem[rd_ptr];

    // Storage: loads the boot contents at reset and writes pushed slots at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= SLOT_W'(boot_slot(i, RESV_SLOT));
            end
        end else if (push) begin
            mem[wr_ptr] <= push_slot;
        end
    end

    // Pointers and occupancy: the queue starts full and both pointers sit at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CNT_W'(DEPTH);
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/kslot_track.sv
// Module: kslot_track
// Keeps one "free" flag per slot and judges each release. A release is accepted only
// for a non-reserved slot that is currently out. Releasing a free slot sets a sticky
// error. Assumes the granted slot is free in the cycle it is granted.
module kslot_track #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic              grant,
    input  logic [SLOT_W-1:0] grant_slot,
    output logic              rel_acc,
    output logic              dup_err
);
    logic [NUM_SLOTS-1:0] is_free;
    logic                 rel_resv;
    logic                 rel_dup;

    // Release judgement: the reserved slot is dropped silently, a free slot is a duplicate.
    always_comb begin
        rel_resv = (rel_slot == SLOT_W'(RESV_SLOT));
        rel_dup  = rel_en && !rel_resv && is_free[rel_slot];
        rel_acc  = rel_en && !rel_resv && !is_free[rel_slot];
    end

    // Free flags: set on an accepted release, cleared on a grant; the grant wins when both name one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                is_free[i] <= (i != RESV_SLOT);
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (grant && grant_slot == SLOT_W'(i))
                    is_free[i] <= 1'b0;
                else if (rel_acc && rel_slot == SLOT_W'(i))
                    is_free[i] <= 1'b1;
            end
        end
    end

    // Sticky duplicate-release flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       dup_err <= 1'b0;
        else if (rel_dup) dup_err <= 1'b1;
    end

endmodule

// File: rtl/kslot_alloc.sv
// Module: kslot_alloc (top)
// Hands out key slots from a first-in first-out free pool and keeps the reserved slot
// out of it. A request is answered one cycle later. A release in the same cycle as a
// request on an empty pool is passed straight to the requester.
// Assumes one request and at most one release per cycle.
module kslot_alloc #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              alloc_vld,
    output logic              alloc_ok,
    output logic [SLOT_W-1:0] alloc_slot,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              dup_err
);
    logic              rel_acc;
    logic              pool_empty;
    logic              bypass;
    logic              grant;
    logic              pool_pop;
    logic              pool_push;
    logic [SLOT_W-1:0] head_slot;
    logic [SLOT_W-1:0] grant_slot;

    // Grant decision: take the head of the pool, or the slot being released when the pool is empty.
    always_comb begin
        pool_empty = (free_cnt == '0);
        bypass     = alloc_req && pool_empty && rel_acc;
        pool_pop   = alloc_req && !pool_empty;
        grant      = pool_pop || bypass;
        pool_push  = rel_acc && !bypass;
        grant_slot = bypass ? rel_slot : head_slot;
    end

    kslot_fifo #(.NUM_SLOTS(NUM_SLOTS), .RESV_SLOT(RESV_SLOT)) pool_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pool_push),
        .push_slot (rel_slot),
        .pop       (pool_pop),
        .head_slot (head_slot),
        .count     (free_cnt)
    );

    kslot_track #(.NUM_SLOTS(NUM_SLOTS), .RESV_SLOT(RESV_SLOT)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel_en     (rel_en),
        .rel_slot   (rel_slot),
        .grant      (grant),
        .grant_slot (grant_slot),
        .rel_acc    (rel_acc),
        .dup_err    (dup_err)
    );

    // Response register: reports each request on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vld  <= 1'b0;
            alloc_ok   <= 1'b0;
            alloc_slot <= '0;
        end else begin
            alloc_vld  <= alloc_req;
            alloc_ok   <= grant;
            alloc_slot <= grant ? grant_slot : '0;
        end
    end

endmodule

// File: rtl/kslot_alloc_chk.sv
// Module: kslot_alloc_chk
// Property checker for kslot_alloc, attached to every instance by the bind below.
module kslot_alloc_chk #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              rel_en,
    input logic [SLOT_W-1:0] rel_slot,
    input logic              alloc_vld,
    input logic              alloc_ok,
    input logic [SLOT_W-1:0] alloc_slot,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              dup_err
);
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) alloc_req |=> alloc_vld); // R3
    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !alloc_req |=> !alloc_vld); // R3
    AST_EMPTY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && free_cnt == '0 && !rel_en) |=> (!alloc_ok && alloc_slot == '0 && free_cnt == '0)); // R4
    AST_RESV_RELEASE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && rel_slot == SLOT_W'(RESV_SLOT) && !alloc_req) |=> $stable(free_cnt)); // R6
    AST_DUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) dup_err |=> dup_err); // R7
    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_req && !rel_en) |=> $stable(free_cnt)); // R8
    AST_NEVER_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && alloc_ok) |-> alloc_slot != SLOT_W'(RESV_SLOT)); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(NUM_SLOTS - 1)); // R10
endmodule

bind kslot_alloc kslot_alloc_chk #(.NUM_SLOTS(NUM_SLOTS), .RESV_SLOT(RESV_SLOT)) chk_i (.*);

// File: tb/kslot_alloc_tb.sv
// Bench for kslot_alloc: a table of per-cycle vectors walked in one loop, then directed tests.
module kslot_alloc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic       rel_en = 1'b0;
    logic [2:0] rel_slot = '0;
    logic       alloc_vld;
    logic       alloc_ok;
    logic [2:0] alloc_slot;
    logic [3:0] free_cnt;
    logic       dup_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    kslot_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .rel_en(rel_en), .rel_slot(rel_slot),
        .alloc_vld(alloc_vld), .alloc_ok(alloc_ok), .alloc_slot(alloc_slot),
        .free_cnt(free_cnt), .dup_err(dup_err)
    );

    // Vector fields: [12] request, [11] release, [10:8] released slot,
    // [7] expected grant, [6:4] expected slot, [3:0] expected free count.
    function automatic logic [12:0] v(input logic a, input logic r, input int rs,
                                       input logic ok, input int sl, input int cnt);
        return {a, r, 3'(rs), ok, 3'(sl), 4'(cnt)};
    endfunction

    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        v(1, 0, 0, 1, 0, 6),  // R2 boot order
        v(1, 0, 0, 1, 1, 5),  // R2
        v(1, 0, 0, 1, 2, 4),  // R2
        v(0, 1, 1, 0, 0, 5),  // R5 slot 1 to tail
        v(1, 1, 0, 1, 3, 5),  // R8 head granted, 0 to tail
        v(0, 1, 4, 0, 0, 5),  // R6 reserved release dropped
        v(1, 0, 0, 1, 5, 4),  // R2 skips slot 4
        v(1, 0, 0, 1, 6, 3),  // R2
        v(1, 0, 0, 1, 7, 2),  // R2
        v(1, 0, 0, 1, 1, 1),  // R5 released slot after older ones
        v(1, 0, 0, 1, 0, 0),  // R5 R8
        v(1, 0, 0, 0, 0, 0),  // R4 empty refusal
        v(1, 1, 2, 1, 2, 0),  // R9 bypass on empty pool
        v(0, 1, 3, 0, 0, 1),  // R5
        v(1, 1, 5, 1, 3, 1),  // R8
        v(1, 0, 0, 1, 5, 0),  // R8 R5
        v(0, 1, 6, 0, 0, 1),  // R5
        v(0, 1, 7, 0, 0, 2)   // R5
    };

    task automatic chk(input logic good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic r, input logic [2:0] rs);
        alloc_req = a;
        rel_en    = r;
        rel_slot  = rs;
        @(negedge clk);
        alloc_req = 1'b0;
        rel_en    = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(free_cnt == 4'd7, "R1 free_cnt", free_cnt, 7);
        chk(dup_err == 1'b0, "R1 dup_err", dup_err, 0);
        chk(alloc_vld == 1'b0, "R1 alloc_vld", alloc_vld, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][12], VEC[i][11], VEC[i][10:8]);
            chk(alloc_vld == VEC[i][12], $sformatf("R3 vec %0d vld", i), alloc_vld, VEC[i][12]);
            chk(alloc_ok == VEC[i][7], $sformatf("R2/R4/R9 vec %0d ok", i), alloc_ok, VEC[i][7]);
            chk(alloc_slot == VEC[i][6:4], $sformatf("R2/R5/R8 vec %0d slot", i), alloc_slot, VEC[i][6:4]);
            chk(free_cnt == VEC[i][3:0], $sformatf("R10 vec %0d count", i), free_cnt, VEC[i][3:0]);
            chk(dup_err == 1'b0, $sformatf("R6 vec %0d no error", i), dup_err, 0);
        end

        // R7: pool holds 6 then 7; releasing 6 again is a duplicate.
        drive(1'b0, 1'b1, 3'd6);
        chk(free_cnt == 4'd2, "R7 count unchanged", free_cnt, 2);
        chk(dup_err == 1'b1, "R7 flag set", dup_err, 1);
        drive(1'b1, 1'b0, 3'd0);
        chk(alloc_ok && alloc_slot == 3'd6, "R7 grant 6", alloc_slot, 6);
        drive(1'b1, 1'b0, 3'd0);
        chk(alloc_ok && alloc_slot == 3'd7, "R7 grant 7", alloc_slot, 7);
        drive(1'b1, 1'b0, 3'd0);
        chk(alloc_ok == 1'b0, "R7 no second copy of 6", alloc_ok, 0);
        chk(free_cnt == 4'd0, "R4 count stays 0", free_cnt, 0);
        drive(1'b0, 1'b0, 3'd0);
        chk(dup_err == 1'b1, "R7 flag sticky", dup_err, 1);
        chk(alloc_vld == 1'b0, "R3 idle cycle", alloc_vld, 0);

        // R1: reset mid-run with a request pending.
        rst_n     = 1'b0;
        alloc_req = 1'b1;
        @(negedge clk);
        alloc_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(free_cnt == 4'd7, "R1 count after reset", free_cnt, 7);
        chk(dup_err == 1'b0, "R1 flag cleared", dup_err, 0);
        chk(alloc_vld == 1'b0, "R1 no response", alloc_vld, 0);
        drive(1'b1, 1'b0, 3'd0);
        chk(alloc_ok && alloc_slot == 3'd0, "R2 first after reset", alloc_slot, 0);

        summary();
        $finish;
    end
endmodule